// File: doc/BRIEF.md
# Designated-Pointer Address Register File

This block holds sixteen 16-bit address registers together with two 4-bit designators. One designator (the program designator) picks the register that serves as the program counter. The other (the data designator) picks the register that serves as the data pointer. Each clock cycle the block receives one operation code, a 4-bit register field and an 8-bit data byte. It drives the address held by the register that the operation selects, and where the operation reads a byte, it drives that byte. At the clock edge it applies the update that the operation asks for.

The updates are:
- increment or decrement of a whole register;
- a byte write into one half of a register;
- the designator changes used for interrupt entry, for saving the designator pair on a subroutine mark, and for restoring it on return.

The 8-bit save register holds the designator pair during these changes. Register 0 is the DMA pointer, register 1 is the interrupt program counter, and register 2 is the stack pointer for the mark operation.

Memory, instruction decoding and arithmetic are outside the block. A surrounding core feeds `din_i` from memory (for restores) or from its accumulator (for byte writes). It takes `addr_o` as the memory address and returns `dout_o` to the accumulator or to memory.

Top module: `dpr_file`

## Requirements
- R1: When `rst` is high at a clock edge, the program designator and the data designator become 0, register 0 becomes 0x0000, the save register becomes 0x00 and the interrupt enable becomes 1.
- R2: Fetch (op 1) drives `addr_o` = R(P), then increments R(P) by one modulo 2^16, so 0xFFFF wraps to 0x0000 and a carry out of the low byte reaches the high byte.
- R3: Increment (op 2) and decrement (op 3) change R(N) by one across all 16 bits, carrying or borrowing between the two bytes.
- R4: Write-low (op 15) puts `din_i` into bits 7:0 of R(N), and write-high (op 16) puts it into bits 15:8. The other byte is left unchanged.
- R5: Read-low (op 13) drives `dout_o` with bits 7:0 of R(N), and read-high (op 14) drives it with bits 15:8. Neither op changes any state. Every operation that outputs no byte drives `dout_o` = 0x00.
- R6: Set-program (op 7) loads N into the program designator, and set-data (op 8) loads N into the data designator.
- R7: Load-advance by N (op 4) addresses R(N) and then increments it. Load-advance by data pointer (op 5) addresses R(X) and then increments it. Store-decrement (op 6) addresses R(X) and then decrements it.
- R8: Interrupt entry (op 9) copies the pair {X,P} (X in bits 7:4) into the save register, sets P to 1 and X to 2, and clears the interrupt enable.
- R9: Mark (op 10) addresses R(2) and drives `dout_o` = {X,P}. It copies {X,P} into the save register, copies P into X, and decrements R(2).
- R10: Restore-enable (op 11) and restore-disable (op 12) address R(X). They load X from `din_i[7:4]` and P from `din_i[3:0]`, and increment the register that X designated before the load. They set the interrupt enable to 1 (op 11) or 0 (op 12).
- R11: DMA step (op 17) drives `addr_o` = R(0), then increments R(0).
- R12: Idle (op 0) addresses R(0). Save-out (op 18) addresses R(X) and drives `dout_o` with the save register. Point-at-data (op 19) addresses R(X). These three ops, and all unassigned codes (20 to 31), leave every register, designator and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation code for this cycle |
| n_i | input | 4 | Register field of the instruction |
| din_i | input | 8 | Byte from memory or from the accumulator |
| addr_o | output | 16 | Contents of the register the operation selects |
| dout_o | output | 8 | Byte read out (register half, designator pair or save register) |
| p_o | output | 4 | Program designator |
| x_o | output | 4 | Data designator |
| ie_o | output | 1 | Interrupt enable |

## Verification
The bound checker checks every cycle the designator and enable changes that are visible at the ports. These are:
- the values after reset;
- the effect of set-program, interrupt entry, restore and mark;
- the stability of all of these under idle and unassigned codes;
- the one-per-cycle address advance of back-to-back fetches and DMA steps.

Register contents cannot be seen at the ports, so only the bench's scenarios can show them. The bench reads the contents back through the byte-read and address outputs. With this it shows the byte carry and borrow of increment and decrement, wrap at 0xFFFF, byte writes that keep the other half, and the stack decrement by mark. It also shows that a restore increments the register designated by the old data designator, not the new one.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = BYTE_W / 2;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int NREG   = 1 << SEL_W;
    localparam int OP_W   = 5;

    localparam logic [SEL_W-1:0] DMA_REG   = SEL_W'(0);
    localparam logic [SEL_W-1:0] IRQ_PC    = SEL_W'(1);
    localparam logic [SEL_W-1:0] IRQ_DP    = SEL_W'(2);
    localparam logic [SEL_W-1:0] STACK_REG = SEL_W'(2);

    typedef enum logic [OP_W-1:0] {
        OP_IDLE        = 5'd0,
        OP_FETCH       = 5'd1,
        OP_INCR        = 5'd2,
        OP_DECR        = 5'd3,
        OP_LDADV_N     = 5'd4,
        OP_LDADV_X     = 5'd5,
        OP_STDEC_X     = 5'd6,
        OP_SET_PC      = 5'd7,
        OP_SET_DP      = 5'd8,
        OP_IRQ         = 5'd9,
        OP_CALL_SAVE   = 5'd10,
        OP_RESTORE_EN  = 5'd11,
        OP_RESTORE_DIS = 5'd12,
        OP_RD_LO       = 5'd13,
        OP_RD_HI       = 5'd14,
        OP_WR_LO       = 5'd15,
        OP_WR_HI       = 5'd16,
        OP_DMA_STEP    = 5'd17,
        OP_TMP_OUT     = 5'd18,
        OP_PTR_X       = 5'd19
    } dpr_op_e;

    typedef enum logic [2:0] {
        SRC_P, SRC_X, SRC_N, SRC_DMA, SRC_STACK
    } src_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_INC, ACT_DEC, ACT_WLO, ACT_WHI
    } act_e;

    typedef struct packed {
        src_e src;
        act_e act;
    } plan_t;

    function automatic plan_t decode_op(input logic [OP_W-1:0] op);
        plan_t pl;
        pl.src = SRC_DMA;
        pl.act = ACT_NONE;
        case (op)
            OP_FETCH:       begin pl.src = SRC_P;     pl.act = ACT_INC; end
            OP_INCR:        begin pl.src = SRC_N;     pl.act = ACT_INC; end
            OP_DECR:        begin pl.src = SRC_N;     pl.act = ACT_DEC; end
            OP_LDADV_N:     begin pl.src = SRC_N;     pl.act = ACT_INC; end
            OP_LDADV_X:     begin pl.src = SRC_X;     pl.act = ACT_INC; end
            OP_STDEC_X:     begin pl.src = SRC_X;     pl.act = ACT_DEC; end
            OP_CALL_SAVE:   begin pl.src = SRC_STACK; pl.act = ACT_DEC; end
            OP_RESTORE_EN,
            OP_RESTORE_DIS: begin pl.src = SRC_X;     pl.act = ACT_INC; end
            OP_RD_LO,
            OP_RD_HI:       pl.src = SRC_N;
            OP_WR_LO:       begin pl.src = SRC_N;     pl.act = ACT_WLO; end
            OP_WR_HI:       begin pl.src = SRC_N;     pl.act = ACT_WHI; end
            OP_DMA_STEP:    begin pl.src = SRC_DMA;   pl.act = ACT_INC; end
            OP_TMP_OUT,
            OP_PTR_X:       pl.src = SRC_X;
            default:        ;
        endcase
        return pl;
    endfunction

    function automatic logic [SEL_W-1:0] pick_index(
        input src_e src, input logic [SEL_W-1:0] p,
        input logic [SEL_W-1:0] x, input logic [SEL_W-1:0] n);
        case (src)
            SRC_P:     return p;
            SRC_X:     return x;
            SRC_N:     return n;
            SRC_STACK: return STACK_REG;
            default:   return DMA_REG;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] next_value(
        input act_e act, input logic [ADDR_W-1:0] cur,
        input logic [BYTE_W-1:0] byte_in);
        case (act)
            ACT_INC: return cur + ADDR_W'(1);
            ACT_DEC: return cur - ADDR_W'(1);
            ACT_WLO: return {cur[ADDR_W-1:BYTE_W], byte_in};
            ACT_WHI: return {byte_in, cur[BYTE_W-1:0]};
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/dpr_bank.sv
module dpr_bank
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  idx_i,
    input  act_e              act_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ADDR_W-1:0] val_o
);
    logic [ADDR_W-1:0] regs [NREG];
    logic [ADDR_W-1:0] upd;
    logic              we;

    assign val_o = regs[idx_i];
    assign upd   = next_value(act_i, val_o, byte_i);
    assign we    = (act_i != ACT_NONE);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(DMA_REG)) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (we && idx_i == SEL_W'(i))
                    regs[i] <= upd;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (we && idx_i == SEL_W'(i))
                    regs[i] <= upd;
            end
        end
    end
endmodule

// File: rtl/dpr_desig.sv
module dpr_desig
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [SEL_W-1:0]  n_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic [SEL_W-1:0]  p_o,
    output logic [SEL_W-1:0]  x_o,
    output logic              ie_o,
    output logic [BYTE_W-1:0] tsave_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            p_o     <= '0;
            x_o     <= '0;
            ie_o    <= 1'b1;
            tsave_o <= '0;
        end else begin
            case (op_i)
                OP_SET_PC: p_o <= n_i;
                OP_SET_DP: x_o <= n_i;
                OP_IRQ: begin
                    tsave_o <= {x_o, p_o};
                    p_o     <= IRQ_PC;
                    x_o     <= IRQ_DP;
                    ie_o    <= 1'b0;
                end
                OP_CALL_SAVE: begin
                    tsave_o <= {x_o, p_o};
                    x_o     <= p_o;
                end
                OP_RESTORE_EN, OP_RESTORE_DIS: begin
                    x_o  <= din_i[BYTE_W-1:SEL_W];
                    p_o  <= din_i[SEL_W-1:0];
                    ie_o <= (op_i == OP_RESTORE_EN);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dpr_file.sv
module dpr_file
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [SEL_W-1:0]  n_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] dout_o,
    output logic [SEL_W-1:0]  p_o,
    output logic [SEL_W-1:0]  x_o,
    output logic              ie_o
);
    plan_t             pl;
    logic [SEL_W-1:0]  idx;
    logic [ADDR_W-1:0] sel_val;
    logic [BYTE_W-1:0] tsave;

    assign pl  = decode_op(op_i);
    assign idx = pick_index(pl.src, p_o, x_o, n_i);

    dpr_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .idx_i  (idx),
        .act_i  (pl.act),
        .byte_i (din_i),
        .val_o  (sel_val)
    );

    dpr_desig u_desig (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op_i),
        .n_i     (n_i),
        .din_i   (din_i),
        .p_o     (p_o),
        .x_o     (x_o),
        .ie_o    (ie_o),
        .tsave_o (tsave)
    );

    assign addr_o = sel_val;

    always_comb begin
        case (op_i)
            OP_RD_LO:     dout_o = sel_val[BYTE_W-1:0];
            OP_RD_HI:     dout_o = sel_val[ADDR_W-1:BYTE_W];
            OP_CALL_SAVE: dout_o = {x_o, p_o};
            OP_TMP_OUT:   dout_o = tsave;
            default:      dout_o = '0;
        endcase
    end
endmodule

// File: rtl/dpr_file_chk.sv
module dpr_file_chk
    import dpr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [SEL_W-1:0]  n_i,
    input logic [BYTE_W-1:0] din_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BYTE_W-1:0] dout_o,
    input logic [SEL_W-1:0]  p_o,
    input logic [SEL_W-1:0]  x_o,
    input logic              ie_o
);
    logic rst_seen = 1'b0;

    always @(posedge clk) begin
        // R1
        if (rst_seen && !rst)
            r1_reset_state_chk: assert (p_o == '0 && x_o == '0 && ie_o == 1'b1);
        rst_seen <= rst;
    end

    // R6
    r6_set_pc_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_SET_PC |=> p_o == $past(n_i));

    // R6
    r6_set_dp_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_SET_DP |=> x_o == $past(n_i));

    // R8
    r8_irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_IRQ |=> (p_o == IRQ_PC && x_o == IRQ_DP && !ie_o));

    // R9
    r9_mark_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_CALL_SAVE |=> (x_o == $past(p_o) && p_o == $past(p_o) && $stable(ie_o)));

    // R10
    r10_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_RESTORE_EN || op_i == OP_RESTORE_DIS) |=>
        (x_o == $past(din_i[7:4]) && p_o == $past(din_i[3:0]) &&
         ie_o == ($past(op_i) == OP_RESTORE_EN)));

    // R2
    r2_fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_FETCH) ##1 (op_i == OP_FETCH) |-> addr_o == $past(addr_o) + 16'd1);

    // R11
    r11_dma_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DMA_STEP) ##1 (op_i == OP_DMA_STEP) |-> addr_o == $past(addr_o) + 16'd1);

    // R12
    r12_quiet_ops_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_IDLE || op_i == OP_TMP_OUT || op_i == OP_PTR_X || op_i > 5'd19) |=>
        ($stable(p_o) && $stable(x_o) && $stable(ie_o)));

    // R5
    r5_quiet_dout_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_IDLE || op_i == OP_FETCH || op_i > 5'd19) |-> dout_o == 8'h00);
endmodule

bind dpr_file dpr_file_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .n_i    (n_i),
    .din_i  (din_i),
    .addr_o (addr_o),
    .dout_o (dout_o),
    .p_o    (p_o),
    .x_o    (x_o),
    .ie_o   (ie_o)
);

// File: tb/tb_dpr_file.sv
module tb_dpr_file;
    import dpr_pkg::*;

    localparam int PERIOD = 10;
    localparam int NVEC   = 57;
    localparam int WDOG   = 5000;

    typedef struct packed {
        logic [4:0]  op;
        logic [3:0]  n;
        logic [7:0]  din;
        logic        ca;
        logic [15:0] a;
        logic        cd;
        logic [7:0]  d;
        logic [3:0]  p;
        logic [3:0]  x;
        logic        ie;
        logic [3:0]  req;
    } vec_t;

    // Each row: op, n, din, check-addr, addr, check-dout, dout, P, X, IE (pre-edge), requirement
    localparam vec_t VEC [NVEC] = '{
        '{5'd0,  4'h0, 8'h00, 1'b1, 16'h0000, 1'b1, 8'h00, 4'h0, 4'h0, 1'b1, 4'd1},  // R1 R12
        '{5'd15, 4'h3, 8'hFF, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd4},  // R4
        '{5'd16, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd4},  // R4
        '{5'd13, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hFF, 4'h0, 4'h0, 1'b1, 4'd5},  // R5
        '{5'd14, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 4'h0, 4'h0, 1'b1, 4'd5},  // R5
        '{5'd2,  4'h3, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd3},  // R3
        '{5'd14, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h01, 4'h0, 4'h0, 1'b1, 4'd3},  // R3 carry
        '{5'd13, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 4'h0, 4'h0, 1'b1, 4'd3},  // R3
        '{5'd3,  4'h3, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd3},  // R3
        '{5'd14, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 4'h0, 4'h0, 1'b1, 4'd3},  // R3 borrow
        '{5'd13, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hFF, 4'h0, 4'h0, 1'b1, 4'd3},  // R3
        '{5'd1,  4'h0, 8'h00, 1'b1, 16'h0000, 1'b1, 8'h00, 4'h0, 4'h0, 1'b1, 4'd2},  // R2
        '{5'd1,  4'h0, 8'h00, 1'b1, 16'h0001, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd2},  // R2
        '{5'd17, 4'h0, 8'h00, 1'b1, 16'h0002, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd11}, // R11
        '{5'd0,  4'h0, 8'h00, 1'b1, 16'h0003, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd11}, // R11
        '{5'd16, 4'h5, 8'h12, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd4},  // R4
        '{5'd15, 4'h5, 8'h34, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd4},  // R4
        '{5'd8,  4'h5, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h0, 1'b1, 4'd6},  // R6
        '{5'd19, 4'h0, 8'h00, 1'b1, 16'h1234, 1'b0, 8'h00, 4'h0, 4'h5, 1'b1, 4'd12}, // R12
        '{5'd5,  4'h0, 8'h00, 1'b1, 16'h1234, 1'b0, 8'h00, 4'h0, 4'h5, 1'b1, 4'd7},  // R7
        '{5'd6,  4'h0, 8'h00, 1'b1, 16'h1235, 1'b0, 8'h00, 4'h0, 4'h5, 1'b1, 4'd7},  // R7
        '{5'd6,  4'h0, 8'h00, 1'b1, 16'h1234, 1'b0, 8'h00, 4'h0, 4'h5, 1'b1, 4'd7},  // R7
        '{5'd4,  4'h5, 8'h00, 1'b1, 16'h1233, 1'b0, 8'h00, 4'h0, 4'h5, 1'b1, 4'd7},  // R7
        '{5'd13, 4'h5, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h34, 4'h0, 4'h5, 1'b1, 4'd7},  // R7
        '{5'd7,  4'h3, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h0, 4'h5, 1'b1, 4'd6},  // R6
        '{5'd1,  4'h0, 8'h00, 1'b1, 16'h00FF, 1'b0, 8'h00, 4'h3, 4'h5, 1'b1, 4'd2},  // R2
        '{5'd14, 4'h3, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h01, 4'h3, 4'h5, 1'b1, 4'd2},  // R2 page carry
        '{5'd16, 4'h2, 8'h20, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h3, 4'h5, 1'b1, 4'd4},  // R4
        '{5'd15, 4'h2, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h3, 4'h5, 1'b1, 4'd4},  // R4
        '{5'd10, 4'h0, 8'h00, 1'b1, 16'h2000, 1'b1, 8'h53, 4'h3, 4'h5, 1'b1, 4'd9},  // R9
        '{5'd14, 4'h2, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h1F, 4'h3, 4'h3, 1'b1, 4'd9},  // R9
        '{5'd13, 4'h2, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hFF, 4'h3, 4'h3, 1'b1, 4'd9},  // R9
        '{5'd18, 4'h0, 8'h00, 1'b1, 16'h0100, 1'b1, 8'h53, 4'h3, 4'h3, 1'b1, 4'd12}, // R12
        '{5'd9,  4'h0, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h3, 4'h3, 1'b1, 4'd8},  // R8
        '{5'd18, 4'h0, 8'h00, 1'b1, 16'h1FFF, 1'b1, 8'h33, 4'h1, 4'h2, 1'b0, 4'd8},  // R8
        '{5'd11, 4'h0, 8'h5A, 1'b1, 16'h1FFF, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd10}, // R10
        '{5'd14, 4'h2, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h20, 4'hA, 4'h5, 1'b1, 4'd10}, // R10 old X
        '{5'd13, 4'h2, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 4'hA, 4'h5, 1'b1, 4'd10}, // R10
        '{5'd13, 4'h5, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h34, 4'hA, 4'h5, 1'b1, 4'd10}, // R10 new X untouched
        '{5'd12, 4'h0, 8'h21, 1'b1, 16'h1234, 1'b0, 8'h00, 4'hA, 4'h5, 1'b1, 4'd10}, // R10
        '{5'd13, 4'h5, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h35, 4'h1, 4'h2, 1'b0, 4'd10}, // R10
        '{5'd31, 4'h5, 8'hFF, 1'b0, 16'h0000, 1'b1, 8'h00, 4'h1, 4'h2, 1'b0, 4'd12}, // R12
        '{5'd13, 4'h5, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h35, 4'h1, 4'h2, 1'b0, 4'd12}, // R12
        '{5'd0,  4'h0, 8'h00, 1'b1, 16'h0003, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd12}, // R12
        '{5'd15, 4'h5, 8'h99, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd4},  // R4
        '{5'd14, 4'h5, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h12, 4'h1, 4'h2, 1'b0, 4'd4},  // R4 high kept
        '{5'd13, 4'h5, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h99, 4'h1, 4'h2, 1'b0, 4'd4},  // R4
        '{5'd16, 4'h7, 8'hFF, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd3},  // R3
        '{5'd15, 4'h7, 8'hFF, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd3},  // R3
        '{5'd2,  4'h7, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd3},  // R3
        '{5'd14, 4'h7, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 4'h1, 4'h2, 1'b0, 4'd3},  // R3 wrap
        '{5'd13, 4'h7, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 4'h1, 4'h2, 1'b0, 4'd3},  // R3
        '{5'd3,  4'h7, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd3},  // R3
        '{5'd14, 4'h7, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hFF, 4'h1, 4'h2, 1'b0, 4'd3},  // R3 borrow wrap
        '{5'd7,  4'h7, 8'h00, 1'b0, 16'h0000, 1'b0, 8'h00, 4'h1, 4'h2, 1'b0, 4'd6},  // R6
        '{5'd1,  4'h0, 8'h00, 1'b1, 16'hFFFF, 1'b0, 8'h00, 4'h7, 4'h2, 1'b0, 4'd2},  // R2
        '{5'd1,  4'h0, 8'h00, 1'b1, 16'h0000, 1'b0, 8'h00, 4'h7, 4'h2, 1'b0, 4'd2}   // R2 wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = 5'd0;
    logic [3:0]  n_i = 4'h0;
    logic [7:0]  din_i = 8'h00;
    logic [15:0] addr_o;
    logic [7:0]  dout_o;
    logic [3:0]  p_o;
    logic [3:0]  x_o;
    logic        ie_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dpr_file dut (
        .clk(clk), .rst(rst), .op_i(op_i), .n_i(n_i), .din_i(din_i),
        .addr_o(addr_o), .dout_o(dout_o), .p_o(p_o), .x_o(x_o), .ie_o(ie_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [3:0] n, input logic [7:0] d);
        @(negedge clk);
        op_i = op; n_i = n; din_i = d;
        #(PERIOD/5);
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].op, VEC[i].n, VEC[i].din);
            if (VEC[i].ca)
                check($sformatf("R%0d vec%0d addr", VEC[i].req, i), addr_o, VEC[i].a);
            if (VEC[i].cd)
                check($sformatf("R%0d vec%0d dout", VEC[i].req, i), {8'h00, dout_o}, {8'h00, VEC[i].d});
            check($sformatf("R%0d vec%0d p/x/ie", VEC[i].req, i),
                  {7'd0, p_o, x_o, ie_o}, {7'd0, VEC[i].p, VEC[i].x, VEC[i].ie});
        end

        // R1: reset mid-run with R0 = 0x0003 and nonzero designators and save register
        drive(OP_IDLE, 4'h0, 8'h00);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #(PERIOD/5);
        check("R1 reset p/x/ie", {7'd0, p_o, x_o, ie_o}, {7'd0, 4'h0, 4'h0, 1'b1});
        check("R1 reset R0 addr", addr_o, 16'h0000);
        drive(OP_TMP_OUT, 4'h0, 8'h00);
        check("R1 reset save reg", {8'h00, dout_o}, 16'h0000);
        check("R12 save-out addr", addr_o, 16'h0000);

        // R11: back-to-back DMA steps from a cleared pointer
        drive(OP_DMA_STEP, 4'h0, 8'h00);
        check("R11 dma first", addr_o, 16'h0000);
        drive(OP_DMA_STEP, 4'h0, 8'h00);
        check("R11 dma second", addr_o, 16'h0001);
        drive(OP_IDLE, 4'h0, 8'h00);
        check("R11 dma after", addr_o, 16'h0002);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule